// File: doc/BRIEF.md
# USART Bit-Rate Clock Generator

This block derives the timing pulses that a serial transmitter and receiver need from the system clock. A single 12-bit reload prescaler produces a base tick once every `divisor + 1` system cycles. A mode-dependent post-stage turns that base tick into two outputs. One is a per-bit transmit tick. The other is a receiver sample tick, which runs at sixteen or eight samples per bit in asynchronous operation. In synchronous master operation the post-stage instead drives a serial clock out of the block.

In synchronous slave operation the prescaler is bypassed. The external serial clock pin is captured by a two-stage synchronizer and then edge-detected. Rising edges produce receive ticks and falling edges produce transmit ticks. Each tick appears a fixed two system cycles after the pin is first sampled at its new level.

Any change to the divisor, the mode or the effective double-speed setting restarts the prescaler from the new divisor at once. It also clears the post-stage. The double-speed control only counts in asynchronous mode, so toggling it in a synchronous mode disturbs nothing.

Top module: `usart_clkgen`

## Requirements
- R1: While `rst` is high (from the first clock edge of reset on), `tx_tick`, `rx_tick` and `sclk_out` are all low, whatever the divisor.
- R2: In asynchronous normal mode (`mode` = 2'b00, `dbl_speed` = 0), `rx_tick` is a one-cycle pulse every `divisor + 1` cycles and `tx_tick` a one-cycle pulse every 16·(`divisor + 1`) cycles. Every `tx_tick` coincides with an `rx_tick`. This holds for any divisor from 0 to 4095.
- R3: In asynchronous double-speed mode (`mode` = 2'b00, `dbl_speed` = 1), `tx_tick` pulses every 8·(`divisor + 1`) cycles, coinciding with an `rx_tick`, and `rx_tick` keeps its `divisor + 1` period.
- R4: In synchronous master mode (`mode` = 2'b01), `sclk_out` is a square wave whose high and low phases each last `divisor + 1` cycles, starting low after reset or a restart. `rx_tick` pulses in the last cycle before each rise and `tx_tick` in the last cycle before each fall.
- R5: In modes 2'b01, 2'b10 and 2'b11, changing `dbl_speed` has no effect on any output.
- R6: In a cycle where `divisor`, `mode` or the effective double-speed setting differs from its value in the previous cycle, no prescaler-derived tick is issued. The first `rx_tick` (or first master half-period end) then follows exactly `divisor + 1` cycles later. In asynchronous mode the first `tx_tick` follows N·(`divisor + 1`) cycles later, where N is 16 or 8.
- R7: `sclk_out` is low in every mode other than 2'b01.
- R8: In synchronous slave mode (`mode` = 2'b10 or 2'b11), each rising edge of `ext_clk_in` yields exactly one one-cycle `rx_tick`. The pulse appears two system cycles after the first cycle in which the pin is high.
- R9: In synchronous slave mode, each falling edge of `ext_clk_in` yields exactly one one-cycle `tx_tick`, with the same two-cycle latency. `tx_tick` and `rx_tick` are never high together.
- R10: In slave mode no edge is lost or duplicated while `ext_clk_in` holds each level for at least three system cycles, which keeps its frequency below a quarter of the system clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| divisor | input | 12 | Prescaler divisor; base tick period is divisor + 1 cycles |
| dbl_speed | input | 1 | Halves the per-bit sample count in asynchronous mode |
| mode | input | 2 | 00 async, 01 sync master, 10/11 sync slave |
| ext_clk_in | input | 1 | External serial clock used in slave mode |
| tx_tick | output | 1 | One-cycle pulse marking a transmit bit boundary |
| rx_tick | output | 1 | One-cycle receiver sample pulse |
| sclk_out | output | 1 | Serial clock driven in master mode, low otherwise |

## Verification
On every cycle the assertions check several relations between outputs. In asynchronous mode each transmit tick falls on a sample tick. In master mode the serial clock rises right after a receive tick, falls right after a transmit tick and never moves without one, except at a restart. In slave mode each tick matches the pin history two and three cycles back, and the two ticks are never high together. The bench scenarios are needed for the things a single-cycle relation cannot show: the absolute periods for small, random and maximum divisors, the 16-versus-8 ratio, the exact restart phase after a configuration change, and the absence of lost or extra slave edges over long random pin waveforms.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;

    // Operating mode; bit 1 selects the external-clock path.
    typedef enum logic [1:0] {
        CK_ASYNC     = 2'b00,
        CK_MASTER    = 2'b01,
        CK_SLAVE     = 2'b10,
        CK_SLAVE_ALT = 2'b11
    } ck_mode_e;

    // Pulses and clock handed from a timing source to the output mux.
    typedef struct packed {
        logic tx;
        logic rx;
        logic sclk;
    } tick_bundle_s;

    localparam tick_bundle_s TICKS_IDLE = '{tx: 1'b0, rx: 1'b0, sclk: 1'b0};

    // Last post-divider count for the selected oversampling ratio.
    function automatic int unsigned ovs_last(input logic fast, input int unsigned norm_ovs,
                                             input int unsigned fast_ovs);
        return fast ? fast_ovs - 1 : norm_ovs - 1;
    endfunction

endpackage

// File: rtl/usart_prescaler.sv
module usart_prescaler #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic             restart,
    output logic             base_tick
);
    logic [DIV_W-1:0] count_q;

    // Down-counter: reload on zero or on a configuration restart.
    always_ff @(posedge clk) begin
        if (rst || restart || count_q == '0) begin
            count_q <= divisor;
        end else begin
            count_q <= count_q - DIV_W'(1);
        end
    end

    assign base_tick = !rst && !restart && (count_q == '0);
endmodule

// File: rtl/usart_async_post.sv
module usart_async_post
    import usart_clkgen_pkg::*;
#(
    parameter int NORM_OVS = 16,
    parameter int FAST_OVS = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         enable,
    input  logic         fast,
    input  logic         base_tick,
    output tick_bundle_s ticks
);
    localparam int PW = $clog2(NORM_OVS);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] last_phase;

    assign last_phase = PW'(ovs_last(fast, NORM_OVS, FAST_OVS));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (enable && base_tick) begin
            phase_q <= (phase_q == last_phase) ? '0 : phase_q + PW'(1);
        end
    end

    always_comb begin
        ticks      = TICKS_IDLE;
        ticks.rx   = base_tick;
        ticks.tx   = base_tick && (phase_q == last_phase);
    end
endmodule

// File: rtl/usart_sync_master.sv
module usart_sync_master
    import usart_clkgen_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         enable,
    input  logic         base_tick,
    output tick_bundle_s ticks
);
    logic sclk_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sclk_q <= 1'b0;
        end else if (enable && base_tick) begin
            sclk_q <= !sclk_q;
        end
    end

    always_comb begin
        ticks.sclk = sclk_q;
        ticks.rx   = base_tick && !sclk_q;
        ticks.tx   = base_tick && sclk_q;
    end
endmodule

// File: rtl/usart_slave_edge.sv
module usart_slave_edge
    import usart_clkgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ext_clk_in,
    output tick_bundle_s ticks
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= ext_clk_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk_in};
            end
        end
    endgenerate

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    always_comb begin
        ticks      = TICKS_IDLE;
        ticks.rx   = !rst && level && !prev_q;
        ticks.tx   = !rst && !level && prev_q;
    end
endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
    import usart_clkgen_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int NORM_OVS    = 16,
    parameter int FAST_OVS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] divisor,
    input  logic             dbl_speed,
    input  logic [1:0]       mode,
    input  logic             ext_clk_in,
    output logic             tx_tick,
    output logic             rx_tick,
    output logic             sclk_out
);
    ck_mode_e         mode_e;
    logic             eff_dbl;
    logic [DIV_W-1:0] div_q;
    logic [1:0]       mode_q;
    logic             dbl_q;
    logic             cfg_change;
    logic             base_tick;
    tick_bundle_s     async_b, master_b, slave_b, sel_b;

    assign mode_e  = ck_mode_e'(mode);
    // Double speed only counts while asynchronous operation is selected.
    assign eff_dbl = dbl_speed && (mode_e == CK_ASYNC);

    // Previous-cycle configuration, used to spot a change.
    always_ff @(posedge clk) begin
        div_q  <= divisor;
        mode_q <= mode;
        dbl_q  <= eff_dbl;
    end

    assign cfg_change = !rst && ((divisor != div_q) || (mode != mode_q) || (eff_dbl != dbl_q));

    usart_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .divisor  (divisor),
        .restart  (cfg_change),
        .base_tick(base_tick)
    );

    usart_async_post #(.NORM_OVS(NORM_OVS), .FAST_OVS(FAST_OVS)) u_async (
        .clk      (clk),
        .rst      (rst),
        .clear    (cfg_change),
        .enable   (mode_e == CK_ASYNC),
        .fast     (eff_dbl),
        .base_tick(base_tick),
        .ticks    (async_b)
    );

    usart_sync_master u_master (
        .clk      (clk),
        .rst      (rst),
        .clear    (cfg_change),
        .enable   (mode_e == CK_MASTER),
        .base_tick(base_tick),
        .ticks    (master_b)
    );

    usart_slave_edge #(.SYNC_STAGES(SYNC_STAGES)) u_slave (
        .clk       (clk),
        .rst       (rst),
        .ext_clk_in(ext_clk_in),
        .ticks     (slave_b)
    );

    always_comb begin
        case (mode_e)
            CK_ASYNC:  sel_b = async_b;
            CK_MASTER: sel_b = master_b;
            default:   sel_b = slave_b;
        endcase
    end

    assign tx_tick  = sel_b.tx;
    assign rx_tick  = sel_b.rx;
    assign sclk_out = sel_b.sclk;
endmodule

// File: rtl/usart_clkgen_chk.sv
module usart_clkgen_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       ext_clk_in,
    input logic       tx_tick,
    input logic       rx_tick,
    input logic       sclk_out,
    input logic       cfg_change
);
    // Cycles since reset release, saturating, so deep $past stays post-reset.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R2 / R3: a bit boundary always lands on a receiver sample
    a_r2_tx_on_sample: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && tx_tick) |-> rx_tick);

    // R4: clock rises right after a receive tick
    a_r4_rise_after_rx: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && rx_tick) |=> (mode != 2'b01 || sclk_out));

    // R4: clock falls right after a transmit tick
    a_r4_fall_after_tx: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && tx_tick) |=> (mode != 2'b01 || !sclk_out));

    // R4 / R6: outside a restart the master clock only moves on a tick
    a_r4_sclk_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && $past(mode) == 2'b01 && !$past(cfg_change)
         && !$past(rx_tick) && !$past(tx_tick)) |-> $stable(sclk_out));

    // R8: a slave receive tick reflects a low-to-high pin history (two-stage sync)
    a_r8_rise_latency: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && rx_tick && age_q == 2'd3) |-> ($past(ext_clk_in, 2) && !$past(ext_clk_in, 3)));

    // R9: a slave transmit tick reflects a high-to-low pin history
    a_r9_fall_latency: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && tx_tick && age_q == 2'd3) |-> (!$past(ext_clk_in, 2) && $past(ext_clk_in, 3)));

    // R9: slave ticks are mutually exclusive
    a_r9_slave_exclusive: assert property (@(posedge clk) disable iff (rst)
        mode[1] |-> !(tx_tick && rx_tick));
endmodule

bind usart_clkgen usart_clkgen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .ext_clk_in(ext_clk_in),
    .tx_tick   (tx_tick),
    .rx_tick   (rx_tick),
    .sclk_out  (sclk_out),
    .cfg_change(cfg_change)
);

// File: tb/test_usart_clkgen.sv
module test_usart_clkgen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] divisor = 12'd0;
    logic        dbl_speed = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        ext_clk_in = 1'b0;
    logic        tx_tick, rx_tick, sclk_out;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 1'b0;

    always #5 clk = !clk;

    usart_clkgen i_usart_clkgen (
        .clk       (clk),
        .rst       (rst),
        .divisor   (divisor),
        .dbl_speed (dbl_speed),
        .mode      (mode),
        .ext_clk_in(ext_clk_in),
        .tx_tick   (tx_tick),
        .rx_tick   (rx_tick),
        .sclk_out  (sclk_out)
    );

    // ---------------- expected-value functions ----------------
    function automatic bit exp_base(input int k, input int d);
        return (k > 0) && (k % (d + 1) == 0);
    endfunction

    function automatic bit exp_async_tx(input int k, input int d, input bit dbl);
        int n = dbl ? 8 : 16;
        return (k > 0) && (k % (n * (d + 1)) == 0);
    endfunction

    function automatic bit exp_master_sclk(input int k, input int d);
        if (k < 1) return 1'b0;
        return (((k - 1) / (d + 1)) % 2) == 1;
    endfunction

    task automatic report(input string tag, input string what, input int bad, input int t,
                          input bit act, input bit exp);
        compared++;
        if (bad > 0) begin
            mismatched++;
            $display("FAIL %s %s: %0d bad cycles, first at t=%0d actual=%0b expected=%0b",
                     tag, what, bad, t, act, exp);
        end
    endtask

    // Counter-driven window: async or master, started by reset or by a config change.
    task automatic run_cnt(input int d, input bit dbl, input logic [1:0] m, input bit via_reset,
                           input int len, input bit jiggle, input string tag);
        int shift;
        int b_rx = 0, b_tx = 0, b_sc = 0;
        int f_rx = 0, f_tx = 0, f_sc = 0;
        bit a_rx = 0, a_tx = 0, a_sc = 0, x_rx = 0, x_tx = 0, x_sc = 0;
        @(negedge clk);
        divisor = 12'(d); dbl_speed = dbl; mode = m;
        if (via_reset) begin
            rst = 1'b1;
            repeat (2) @(negedge clk);
            rst = 1'b0;
        end
        shift = via_reset ? 1 : 0;
        for (int t = 0; t < len; t++) begin
            int k;
            bit e_rx, e_tx, e_sc;
            if (t > 0) @(negedge clk);
            if (jiggle && t > 0 && t % 5 == 0) dbl_speed = !dbl_speed;
            #1;
            k = t + shift;
            if (m == 2'b00) begin
                e_rx = exp_base(k, d);
                e_tx = exp_async_tx(k, d, dbl);
                e_sc = 1'b0;
            end else begin
                e_sc = exp_master_sclk(k, d);
                e_rx = exp_base(k, d) && !e_sc;
                e_tx = exp_base(k, d) && e_sc;
            end
            if (rx_tick !== e_rx) begin
                if (b_rx == 0) begin f_rx = t; a_rx = rx_tick; x_rx = e_rx; end
                b_rx++;
            end
            if (tx_tick !== e_tx) begin
                if (b_tx == 0) begin f_tx = t; a_tx = tx_tick; x_tx = e_tx; end
                b_tx++;
            end
            if (k > 0 && sclk_out !== e_sc) begin
                if (b_sc == 0) begin f_sc = t; a_sc = sclk_out; x_sc = e_sc; end
                b_sc++;
            end
        end
        report(tag, "rx_tick", b_rx, f_rx, a_rx, x_rx);
        report(tag, "tx_tick", b_tx, f_tx, a_tx, x_tx);
        report((m == 2'b01) ? "R4" : "R7", "sclk_out", b_sc, f_sc, a_sc, x_sc);
    endtask

    // Slave window: random pin waveform, each level held 3..6 cycles (R10).
    task automatic run_slave(input logic [1:0] m, input int len);
        bit hist[0:511];
        bit level = 1'b0;
        int hold  = 3;
        int b_rx = 0, b_tx = 0, b_sc = 0, f_rx = 0, f_tx = 0, f_sc = 0;
        bit a_rx = 0, a_tx = 0, x_rx = 0, x_tx = 0;
        @(negedge clk);
        mode = m; ext_clk_in = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int t = 0; t < len; t++) begin
            bit e_rx, e_tx;
            if (t > 0) @(negedge clk);
            if (hold == 0) begin
                level = !level;
                hold  = 3 + int'($urandom_range(3));
            end
            hold--;
            ext_clk_in = level;
            hist[t]    = level;
            if (t % 4 == 1) dbl_speed = !dbl_speed;   // R5: must not matter here
            #1;
            e_rx = (t >= 3) && hist[t-2] && !hist[t-3];
            e_tx = (t >= 3) && !hist[t-2] && hist[t-3];
            if (rx_tick !== e_rx) begin
                if (b_rx == 0) begin f_rx = t; a_rx = rx_tick; x_rx = e_rx; end
                b_rx++;
            end
            if (tx_tick !== e_tx) begin
                if (b_tx == 0) begin f_tx = t; a_tx = tx_tick; x_tx = e_tx; end
                b_tx++;
            end
            if (sclk_out !== 1'b0) begin
                if (b_sc == 0) f_sc = t;
                b_sc++;
            end
        end
        report("R8 R10 R5", "rx_tick", b_rx, f_rx, a_rx, x_rx);
        report("R9 R10 R5", "tx_tick", b_tx, f_tx, a_tx, x_tx);
        report("R7", "sclk_out", b_sc, f_sc, 1'b1, 1'b0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        int seed;
        int pd = 0;
        bit pdbl = 0;
        logic [1:0] pm = 2'b00;
        seed = $urandom(32'd20240611);

        // R1: outputs quiet during reset even with divisor 0 (counter sits at zero)
        divisor = 12'd0; mode = 2'b01; rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        report("R1", "tx/rx/sclk in reset", (tx_tick || rx_tick || sclk_out) ? 1 : 0, 0,
               tx_tick || rx_tick || sclk_out, 1'b0);

        // Directed corner cases
        run_cnt(0, 0, 2'b00, 1, 40, 0, "R2");
        run_cnt(0, 1, 2'b00, 1, 30, 0, "R3");
        run_cnt(0, 0, 2'b01, 1, 20, 0, "R4");
        run_cnt(3, 1, 2'b01, 1, 40, 1, "R5");
        run_cnt(4095, 0, 2'b00, 1, 2 * 4096 + 4, 0, "R2");
        run_cnt(5, 0, 2'b00, 1, 50, 0, "R2");
        run_cnt(2, 0, 2'b00, 0, 120, 0, "R6 R2");   // divisor write mid-stream
        run_cnt(2, 1, 2'b00, 0, 60, 0, "R6 R3");    // only double speed changes
        run_cnt(6, 0, 2'b01, 0, 50, 1, "R6 R5");    // async -> master
        pd = 6; pdbl = 0; pm = 2'b01;

        // Constrained random configurations
        for (int i = 0; i < 14; i++) begin
            int d;
            bit dbl, vr;
            logic [1:0] m;
            bit same;
            string tag;
            d   = int'($urandom_range(24));
            dbl = 1'($urandom_range(1));
            m   = ($urandom_range(1) == 1) ? 2'b01 : 2'b00;
            vr  = 1'($urandom_range(1));
            same = (d == pd) && (m == pm) && ((m == 2'b00 ? dbl : 1'b0) == pdbl);
            if (same) vr = 1'b1;
            if (m == 2'b01)  tag = "R4";
            else if (dbl)    tag = "R3";
            else             tag = "R2";
            if (!vr) tag = {"R6 ", tag};
            run_cnt(d, dbl, m, vr,
                    (m == 2'b00) ? 2 * (dbl ? 8 : 16) * (d + 1) + 3 : 6 * (d + 1) + 3,
                    (m == 2'b01), tag);
            pd = d; pm = m; pdbl = (m == 2'b00) ? dbl : 1'b0;
        end

        // Slave mode, both encodings
        run_slave(2'b10, 400);
        run_slave(2'b11, 400);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule